// File: doc/BRIEF.md
# One-Time-Programmable Security Register Controller

This block serves the security register commands of a serial flash slave. The register is 128 bytes. The lower 64 bytes are erased (all ones) after reset and can be written exactly once by the user. The upper 64 bytes are locked and return a fixed fill value. The block does not sample the serial lines itself. A byte-level shifter in front of it reports several events: chip-select falling and rising, each complete byte received, a flag saying chip-select rose in the middle of a byte, and each output shift strobe. The block gets its write-enable latch set from a separate command decoder.

A program command has four parts: the program opcode, three address bytes, and then any number of data bytes. The data bytes are staged through the shared page buffer, which the block writes through an output port. When chip-select rises, the framing is validated. A well-formed command starts a timed program cycle, during which busy is reported. An ill-formed command, or any command after the user portion has been programmed once, is dropped. In both cases the write-enable latch is cleared. A read command has the read opcode, three address bytes and two dummy bytes. After that, bytes are shifted out MSB first and the address wraps at the top of the register.

Top module: `otp_secreg_ctrl`

## Requirements
- R1: After reset, `wel_o`, `busy_o`, `locked_o`, `so_oe_o` and `pbuf_we_o` are all 0.
- R2: A `wel_set_i` pulse while not busy sets `wel_o` to 1 from the next cycle.
- R3: Opcode 8'h9B, three address bytes (the register offset is the low 7 bits of the third), at least one data byte, then chip-select rising on a byte boundary, with `wel_o`=1 at the opcode and the register never programmed. This gives `busy_o`=1 and `wel_o`=0 in the cycle after the rise. `busy_o` stays 1 for exactly PROG_CYCLES cycles. When it falls, `locked_o` becomes 1 and stays 1.
- R4: Each accepted program data byte pulses `pbuf_we_o` for one cycle, with `pbuf_addr_o` equal to its register offset and `pbuf_data_o` equal to the byte. This happens even if the command is later aborted.
- R5: A program command whose chip-select rises before the third address byte, or with no data byte, leaves `busy_o` at 0 and clears `wel_o`.
- R6: A program command whose chip-select rises with the partial-byte flag set leaves `busy_o` at 0 and clears `wel_o`.
- R7: Once `locked_o`=1, a further well-formed program command leaves `busy_o` at 0, clears `wel_o`, and leaves the register contents unchanged.
- R8: Opcode 8'h77, three address bytes, then two dummy bytes. In the cycle after the last dummy byte, `so_oe_o`=1 and `so_o` carries bit 7 of the addressed byte. Each `bit_tick_i` moves to the next lower bit, and after bit 0 to bit 7 of the next byte.
- R9: A read that passes offset 8'h7F continues at offset 0 with no gap.
- R10: The cycle after a chip-select rise, `so_oe_o` is 0, whatever bit of a byte was being shifted.
- R11: Program data bytes beyond offset 63 are dropped: no page buffer write, no change. Offsets 64 to 127 always read FACTORY_FILL.
- R12: A program opcode with `wel_o`=0, or any command while `busy_o`=1, is ignored: no busy, no page buffer write, no serial output.
- R13: User bytes that a program command did not send keep the value 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start_i | input | 1 | Pulse: chip-select fell, command begins |
| cs_end_i | input | 1 | Pulse: chip-select rose, command ends |
| cs_partial_i | input | 1 | With `cs_end_i`: the rise came inside a byte |
| byte_vld_i | input | 1 | Pulse: a full byte was received |
| byte_i | input | 8 | Received byte |
| bit_tick_i | input | 1 | Pulse: shift the next output bit |
| wel_set_i | input | 1 | Pulse: set the write-enable latch |
| wel_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | Program cycle in progress |
| locked_o | output | 1 | User portion already programmed |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Serial output enable (0 = high impedance) |
| pbuf_we_o | output | 1 | Page buffer write strobe |
| pbuf_addr_o | output | PBUF_AW | Page buffer write address |
| pbuf_data_o | output | 8 | Page buffer write data |

## Verification
Several properties are checked on every cycle: busy lasts exactly the programmed length, the write-enable latch is low once busy rises, and the locked flag is sticky and follows every completed cycle. They also cover no page buffer write while busy, a partial-byte end never starting a program, and the output enable dropping after any chip-select rise. Other behaviour shows only through the bench's scenarios. This covers the byte values that are read back, including the wrap and the locked region, the dropping of bytes past the user region, and each abort reason. It also covers the ignored program without write enable and the refusal of a second program with the contents unchanged.

// File: rtl/otp_sec_pkg.sv
package otp_sec_pkg;
  localparam logic [7:0] OPC_PROG  = 8'h9B;
  localparam logic [7:0] OPC_READ  = 8'h77;
  localparam int         ADDR_LEN  = 3;
  localparam int         DUMMY_LEN = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_PDATA,
    PH_RDATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_sec_pkg::*;
#(
  parameter int REG_BYTES  = 128,
  parameter int USER_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_start_i,
  input  logic                          cs_end_i,
  input  logic                          cs_partial_i,
  input  logic                          byte_vld_i,
  input  logic [7:0]                    byte_i,
  input  logic                          wel_i,
  input  logic                          busy_i,
  input  logic                          locked_i,
  output logic                          stg_clr_o,
  output logic                          stg_we_o,
  output logic [$clog2(USER_BYTES)-1:0] stg_idx_o,
  output logic [7:0]                    stg_data_o,
  output logic                          prog_go_o,
  output logic                          prog_abort_o,
  output logic                          rd_start_o,
  output logic [$clog2(REG_BYTES)-1:0]  rd_addr_o
);
  localparam int AW = $clog2(REG_BYTES);
  localparam int UW = $clog2(USER_BYTES);

  phase_e        phase_q, phase_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          prog_q, prog_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] pidx_q, pidx_d;
  logic          past_q, past_d;
  logic          got_q, got_d;
  logic          framed_ok;

  // a program is well framed if data arrived and CS rose on a byte boundary
  assign framed_ok = (phase_q == PH_PDATA) && got_q && !cs_partial_i;

  always_comb begin
    phase_d      = phase_q;
    cnt_d        = cnt_q;
    prog_d       = prog_q;
    addr_d       = addr_q;
    pidx_d       = pidx_q;
    past_d       = past_q;
    got_d        = got_q;
    stg_clr_o    = 1'b0;
    stg_we_o     = 1'b0;
    prog_go_o    = 1'b0;
    prog_abort_o = 1'b0;
    rd_start_o   = 1'b0;
    if (cs_end_i) begin
      if (prog_q && (phase_q == PH_ADDR || phase_q == PH_PDATA)) begin
        if (framed_ok && !locked_i) prog_go_o    = 1'b1;
        else                        prog_abort_o = 1'b1;
      end
      phase_d = PH_IDLE;
      prog_d  = 1'b0;
    end else if (cs_start_i) begin
      phase_d = PH_OPC;
      cnt_d   = '0;
      prog_d  = 1'b0;
      got_d   = 1'b0;
    end else if (byte_vld_i) begin
      unique case (phase_q)
        PH_OPC: begin
          if (busy_i) begin
            phase_d = PH_SKIP;
          end else if (byte_i == OPC_PROG && wel_i) begin
            phase_d   = PH_ADDR;
            prog_d    = 1'b1;
            stg_clr_o = 1'b1;
          end else if (byte_i == OPC_READ) begin
            phase_d = PH_ADDR;
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_ADDR: begin
          cnt_d  = cnt_q + 2'd1;
          addr_d = byte_i[AW-1:0];
          if (cnt_q == 2'(ADDR_LEN - 1)) begin
            cnt_d = '0;
            if (prog_q) begin
              phase_d = PH_PDATA;
              pidx_d  = byte_i[AW-1:0];
              past_d  = {1'b0, byte_i[AW-1:0]} >= (AW+1)'(USER_BYTES);
            end else begin
              phase_d = PH_DUMMY;
            end
          end
        end
        PH_DUMMY: begin
          cnt_d = cnt_q + 2'd1;
          if (cnt_q == 2'(DUMMY_LEN - 1)) begin
            phase_d    = PH_RDATA;
            rd_start_o = 1'b1;
          end
        end
        PH_PDATA: begin
          got_d = 1'b1;
          if (!past_q) begin
            stg_we_o = 1'b1;
            pidx_d   = pidx_q + 1'b1;
            if (pidx_q == AW'(USER_BYTES - 1)) past_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      prog_q  <= 1'b0;
      addr_q  <= '0;
      pidx_q  <= '0;
      past_q  <= 1'b0;
      got_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      prog_q  <= prog_d;
      addr_q  <= addr_d;
      pidx_q  <= pidx_d;
      past_q  <= past_d;
      got_q   <= got_d;
    end
  end

  assign stg_idx_o  = pidx_q[UW-1:0];
  assign stg_data_o = byte_i;
  assign rd_addr_o  = addr_q;
endmodule

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wel_set_i,
  input  logic prog_go_i,
  input  logic prog_abort_i,
  output logic wel_o,
  output logic busy_o,
  output logic locked_o,
  output logic commit_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic          busy_q, busy_d;
  logic          wel_q, wel_d;
  logic          lock_q, lock_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d   = busy_q;
    wel_d    = wel_q;
    lock_d   = lock_q;
    cnt_d    = cnt_q;
    commit_o = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d   = 1'b0;
        lock_d   = 1'b1;
        commit_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (prog_go_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(PROG_CYCLES - 1);
    end
    if (prog_go_i || prog_abort_i)   wel_d = 1'b0;
    else if (wel_set_i && !busy_q)   wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wel_q  <= wel_d;
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wel_o    = wel_q;
  assign busy_o   = busy_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int         REG_BYTES    = 128,
  parameter int         USER_BYTES   = 64,
  parameter logic [7:0] FACTORY_FILL = 8'h00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stg_clr_i,
  input  logic                          stg_we_i,
  input  logic [$clog2(USER_BYTES)-1:0] stg_idx_i,
  input  logic [7:0]                    stg_data_i,
  input  logic                          commit_i,
  input  logic [$clog2(REG_BYTES)-1:0]  rd_addr_i,
  output logic [7:0]                    rd_byte_o
);
  localparam int AW = $clog2(REG_BYTES);
  localparam int UW = $clog2(USER_BYTES);

  logic [USER_BYTES-1:0] mask_q, mask_d;
  logic [7:0]            user_rd [USER_BYTES];

  always_comb begin
    mask_d = mask_q;
    if (stg_clr_i)     mask_d = '0;
    else if (stg_we_i) mask_d[stg_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < USER_BYTES; i++) begin : g_cell
    logic [7:0] user_q;
    logic [7:0] stage_q;
    logic       ld_stage;
    logic       ld_user;

    assign ld_stage = stg_we_i && (stg_idx_i == UW'(i));
    assign ld_user  = commit_i && mask_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       user_q <= 8'hFF;
      else if (ld_user) user_q <= stage_q;
    end

    always_ff @(posedge clk) begin
      if (ld_stage) stage_q <= stg_data_i;
    end

    assign user_rd[i] = user_q;
  end

  assign rd_byte_o = ({1'b0, rd_addr_i} < (AW+1)'(USER_BYTES)) ?
                     user_rd[rd_addr_i[UW-1:0]] : FACTORY_FILL;
endmodule

// File: rtl/otp_read_shift.sv
module otp_read_shift #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          bit_tick_i,
  input  logic          cs_end_i,
  input  logic [7:0]    rd_byte_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          so_o,
  output logic          so_oe_o
);
  logic          act_q, act_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    sh_q, sh_d;
  logic [2:0]    bit_q, bit_d;

  // byte to fetch: start address on entry, otherwise the following one
  assign rd_addr_o = rd_start_i ? start_addr_i : addr_q + 1'b1;

  always_comb begin
    act_d  = act_q;
    addr_d = addr_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    if (cs_end_i) begin
      act_d = 1'b0;
    end else if (rd_start_i) begin
      act_d  = 1'b1;
      addr_d = start_addr_i;
      sh_d   = rd_byte_i;
      bit_d  = '0;
    end else if (act_q && bit_tick_i) begin
      if (bit_q == 3'd7) begin
        addr_d = addr_q + 1'b1;
        sh_d   = rd_byte_i;
        bit_d  = '0;
      end else begin
        sh_d  = {sh_q[6:0], 1'b0};
        bit_d = bit_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
    end
  end

  assign so_o    = act_q & sh_q[7];
  assign so_oe_o = act_q;
endmodule

// File: rtl/otp_secreg_ctrl.sv
module otp_secreg_ctrl #(
  parameter int         REG_BYTES    = 128,
  parameter int         USER_BYTES   = 64,
  parameter int         PROG_CYCLES  = 200,
  parameter int         PBUF_AW      = 8,
  parameter logic [7:0] FACTORY_FILL = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_start_i,
  input  logic               cs_end_i,
  input  logic               cs_partial_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               bit_tick_i,
  input  logic               wel_set_i,
  output logic               wel_o,
  output logic               busy_o,
  output logic               locked_o,
  output logic               so_o,
  output logic               so_oe_o,
  output logic               pbuf_we_o,
  output logic [PBUF_AW-1:0] pbuf_addr_o,
  output logic [7:0]         pbuf_data_o
);
  localparam int AW = $clog2(REG_BYTES);
  localparam int UW = $clog2(USER_BYTES);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          stg_clr, stg_we, prog_go, prog_abort, rd_start, commit;
  logic [UW-1:0] stg_idx;
  logic [7:0]    stg_data, rd_byte;
  logic [AW-1:0] dec_addr, fetch_addr;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  otp_cmd_decode #(.REG_BYTES(REG_BYTES), .USER_BYTES(USER_BYTES)) i_dec (
    .clk(clk), .rst_n(rst_int_n),
    .cs_start_i(cs_start_i), .cs_end_i(cs_end_i), .cs_partial_i(cs_partial_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .wel_i(wel_o), .busy_i(busy_o), .locked_i(locked_o),
    .stg_clr_o(stg_clr), .stg_we_o(stg_we), .stg_idx_o(stg_idx),
    .stg_data_o(stg_data), .prog_go_o(prog_go), .prog_abort_o(prog_abort),
    .rd_start_o(rd_start), .rd_addr_o(dec_addr)
  );

  otp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_tmr (
    .clk(clk), .rst_n(rst_int_n),
    .wel_set_i(wel_set_i), .prog_go_i(prog_go), .prog_abort_i(prog_abort),
    .wel_o(wel_o), .busy_o(busy_o), .locked_o(locked_o), .commit_o(commit)
  );

  otp_store #(.REG_BYTES(REG_BYTES), .USER_BYTES(USER_BYTES),
              .FACTORY_FILL(FACTORY_FILL)) i_store (
    .clk(clk), .rst_n(rst_int_n),
    .stg_clr_i(stg_clr), .stg_we_i(stg_we), .stg_idx_i(stg_idx),
    .stg_data_i(stg_data), .commit_i(commit),
    .rd_addr_i(fetch_addr), .rd_byte_o(rd_byte)
  );

  otp_read_shift #(.AW(AW)) i_shift (
    .clk(clk), .rst_n(rst_int_n),
    .rd_start_i(rd_start), .start_addr_i(dec_addr), .bit_tick_i(bit_tick_i),
    .cs_end_i(cs_end_i), .rd_byte_i(rd_byte),
    .rd_addr_o(fetch_addr), .so_o(so_o), .so_oe_o(so_oe_o)
  );

  assign pbuf_we_o   = stg_we;
  assign pbuf_addr_o = PBUF_AW'(stg_idx);
  assign pbuf_data_o = stg_data;
endmodule

// File: rtl/otp_secreg_chk.sv
module otp_secreg_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_end,
  input logic cs_partial,
  input logic busy,
  input logic wel,
  input logic locked,
  input logic so_oe,
  input logic pbuf_we
);
  int blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == PROG_CYCLES)); // R3
  AST_WEL_LOW_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel); // R3
  AST_LOCK_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> locked); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R3
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R12
  AST_NO_PBUF_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pbuf_we); // R12
  AST_PARTIAL_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && cs_partial) |=> !$rose(busy)); // R6
  AST_OE_DROP_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> !so_oe); // R10
endmodule

bind otp_secreg_ctrl otp_secreg_chk #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_end(cs_end_i), .cs_partial(cs_partial_i),
  .busy(busy_o), .wel(wel_o), .locked(locked_o), .so_oe(so_oe_o),
  .pbuf_we(pbuf_we_o)
);

// File: tb/test_otp_secreg_ctrl.sv
module test_otp_secreg_ctrl;
  localparam int         PROG = 40;
  localparam logic [7:0] FILL = 8'hC3;

  logic       clk, rst_n;
  logic       cs_start, cs_end, cs_partial, byte_vld, bit_tick, wel_set;
  logic [7:0] byte_in;
  logic       wel, busy, locked, so, so_oe, pbuf_we;
  logic [7:0] pbuf_addr, pbuf_data;

  int         n_chk, n_err, pb_cnt, busy_len;
  logic [7:0] pb_addr_last, pb_data_last;
  logic [7:0] ref_mem [128];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  otp_secreg_ctrl #(.PROG_CYCLES(PROG), .FACTORY_FILL(FILL)) i_otp_secreg_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_start_i(cs_start), .cs_end_i(cs_end),
    .cs_partial_i(cs_partial), .byte_vld_i(byte_vld), .byte_i(byte_in),
    .bit_tick_i(bit_tick), .wel_set_i(wel_set), .wel_o(wel), .busy_o(busy),
    .locked_o(locked), .so_o(so), .so_oe_o(so_oe), .pbuf_we_o(pbuf_we),
    .pbuf_addr_o(pbuf_addr), .pbuf_data_o(pbuf_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (pbuf_we) begin
      pb_cnt++;
      pb_addr_last = pbuf_addr;
      pb_data_last = pbuf_data;
    end
  end

  always @(negedge clk) if (busy) busy_len++;

  // monitor: assemble serial bytes and compare with the scoreboard
  initial begin
    int         nb;
    logic [7:0] acc;
    logic [7:0] e;
    string      t;
    logic       tk, seen;
    nb = 0; acc = '0; seen = 1'b0;
    forever begin
      @(posedge clk);
      tk = bit_tick;
      @(negedge clk);
      #1;
      if (so_oe) begin
        if (!seen || tk) begin
          acc  = {acc[6:0], so};
          nb++;
          seen = 1'b1;
          if (nb == 8) begin
            nb = 0;
            if (exp_q.size() == 0) begin
              check(1'b0, "R8 unexpected byte", 32'(acc), 32'h0);
            end else begin
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              check(acc == e, t, 32'(acc), 32'(e));
            end
          end
        end
      end else begin
        seen = 1'b0;
        nb   = 0;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_in = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic cs_begin();
    @(negedge clk); cs_start = 1'b1;
    @(negedge clk); cs_start = 1'b0;
  endtask

  task automatic cs_finish(input logic part);
    @(negedge clk); cs_end = 1'b1; cs_partial = part;
    @(negedge clk); cs_end = 1'b0; cs_partial = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic set_wel();
    @(negedge clk); wel_set = 1'b1;
    @(negedge clk); wel_set = 1'b0;
    #1;
  endtask

  task automatic read_hdr(input logic [7:0] a);
    cs_begin();
    send_byte(8'h77);
    send_byte(8'h00); send_byte(8'h00); send_byte(a);
    send_byte(8'h00); send_byte(8'h00);
  endtask

  task automatic read_cmd(input logic [7:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[(a + i) % 128]);
      tag_q.push_back(tag);
    end
    read_hdr(a);
    repeat (n * 8 - 1) tick();
    cs_finish(1'b0);
    wait_cyc(2);
  endtask

  task automatic prog_hdr(input logic [7:0] a);
    cs_begin();
    send_byte(8'h9B);
    send_byte(8'h00); send_byte(8'h00); send_byte(a);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int pb0;
    n_chk = 0; n_err = 0; pb_cnt = 0; busy_len = 0;
    pb_addr_last = '0; pb_data_last = '0;
    for (int i = 0; i < 128; i++) ref_mem[i] = (i < 64) ? 8'hFF : FILL;
    rst_n = 1'b0; cs_start = 0; cs_end = 0; cs_partial = 0;
    byte_vld = 0; byte_in = '0; bit_tick = 0; wel_set = 0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    #1;
    // R1 reset state
    check(!wel && !busy && !locked && !so_oe && !pbuf_we, "R1",
          {27'b0, wel, busy, locked, so_oe, pbuf_we}, 32'h0);

    // R13 erased user bytes, R8 basic read
    read_cmd(8'h00, 2, "R13");

    // R12 program without write enable
    pb0 = pb_cnt;
    prog_hdr(8'h10); send_byte(8'hAA); cs_finish(1'b0);
    wait_cyc(1);
    check(!busy && !wel, "R12 no-wel busy", 32'(busy), 32'h0);
    check(pb_cnt == pb0, "R12 no-wel pbuf", 32'(pb_cnt), 32'(pb0));

    // R2 write enable set
    set_wel();
    check(wel == 1'b1, "R2", 32'(wel), 32'h1);

    // R5 incomplete address
    cs_begin(); send_byte(8'h9B); send_byte(8'h00); send_byte(8'h00);
    cs_finish(1'b0);
    check(!wel && !busy, "R5 short addr", {30'b0, wel, busy}, 32'h0);

    // R5 no data byte
    set_wel();
    prog_hdr(8'h10); cs_finish(1'b0);
    check(!wel && !busy, "R5 no data", {30'b0, wel, busy}, 32'h0);

    // R6 partial final byte; R4 page buffer still written
    set_wel();
    pb0 = pb_cnt;
    prog_hdr(8'h10); send_byte(8'h11); cs_finish(1'b1);
    check(!wel && !busy, "R6", {30'b0, wel, busy}, 32'h0);
    check(pb_cnt == pb0 + 1 && pb_addr_last == 8'h10 && pb_data_last == 8'h11,
          "R4 abort pbuf", {pb_addr_last, pb_data_last}, 32'h1011);

    // R3 valid program, R11 third byte past offset 63 dropped
    set_wel();
    pb0 = pb_cnt;
    busy_len = 0;
    prog_hdr(8'h3E); send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    cs_finish(1'b0);
    check(busy && !wel, "R3 start", {30'b0, busy, wel}, 32'h2);
    check(pb_cnt == pb0 + 2, "R11 dropped byte", 32'(pb_cnt), 32'(pb0 + 2));
    check(pb_addr_last == 8'h3F && pb_data_last == 8'h34, "R4 pbuf",
          {pb_addr_last, pb_data_last}, 32'h3F34);
    ref_mem[8'h3E] = 8'h12;
    ref_mem[8'h3F] = 8'h34;

    // R12 read ignored while busy
    read_hdr(8'h00);
    wait_cyc(1);
    #1;
    check(!so_oe, "R12 busy read", 32'(so_oe), 32'h0);
    cs_finish(1'b0);
    while (busy) @(negedge clk);
    #1;
    check(busy_len == PROG, "R3 busy length", 32'(busy_len), 32'(PROG));
    check(locked == 1'b1, "R3 locked", 32'(locked), 32'h1);

    // R8/R11/R13 read across user and locked region
    read_cmd(8'h3C, 2, "R13");
    read_cmd(8'h3E, 4, "R11");
    // R9 wrap
    read_cmd(8'h7E, 4, "R9");

    // R10 read ended mid byte
    read_hdr(8'h3E);
    #1;
    check(so_oe && so == 1'b0, "R8 first bit", {30'b0, so_oe, so}, 32'h2);
    tick(); tick(); tick();
    #1;
    check(so == 1'b1, "R8 bit4", 32'(so), 32'h1);
    cs_finish(1'b0);
    check(!so_oe, "R10", 32'(so_oe), 32'h0);

    // R7 second program refused
    set_wel();
    check(wel == 1'b1, "R2 again", 32'(wel), 32'h1);
    prog_hdr(8'h00); send_byte(8'h55); cs_finish(1'b0);
    check(!wel && !busy, "R7 refused", {30'b0, wel, busy}, 32'h0);
    wait_cyc(3);
    #1;
    check(!busy, "R7 no busy", 32'(busy), 32'h0);
    read_cmd(8'h00, 1, "R7");
    read_cmd(8'h3F, 1, "R7");

    wait_cyc(4);
    check(exp_q.size() == 0, "R8 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule